// File: doc/BRIEF.md
# Process Run Queue Manager

This block keeps the two ready lists of a hardware process scheduler. A process is named by its workspace pointer. Bit 0 of that pointer is the priority: 0 means high, 1 means low. The lists are not held in the block. Each queued process carries its own link in memory. The word eight bytes below its workspace (with bit 0 cleared) holds the pointer of the process queued behind it. The word four bytes below holds its saved resume address. The block itself keeps only a front and a back register for each priority.

A scheduler hands the block an enqueue command, carrying the workspace pointer and the resume address, or a dequeue command. The block then walks the needed memory reads and writes over a simple request/acknowledge port and reports busy while it works. When a command ends it pulses a done strobe. For a dequeue it presents the chosen process's workspace pointer and resume address. If both lists are empty, a dequeue ends at once with an idle flag and a null pointer.

Top module: `procQueueMgr`

## Requirements
- R1: After reset, busy, doneValid, idle and memReq are 0, and both queues are empty, so a first dequeue reports idle.
- R2: An accepted enqueue (cmdOp = 0) first writes cmdIptr to address {cmdWptr[W-1:1],0} minus 4. Workspace pointers are word aligned apart from bit 0, so every memory address has its two low bits at 0.
- R3: If the target queue is already non-empty, the enqueue then writes cmdWptr (with its priority bit) to the old back's cleared pointer minus 8 and makes cmdWptr the back. If the target queue is empty, no second access is made and front and back both become cmdWptr.
- R4: cmdWptr bit 0 = 0 selects the high queue and bit 0 = 1 selects the low queue. A dequeue serves the high queue whenever it is non-empty.
- R5: A dequeue (cmdOp = 1) reads the front's minus-4 word and returns it as outIptr, with the front as outWptr. If more entries remain, it then reads the front's minus-8 word, which becomes the new front. Order within one queue is first in, first out.
- R6: A dequeue of a queue's last entry makes only the minus-4 read and leaves that queue empty.
- R7: A dequeue with both queues empty makes no memory access. It raises doneValid in the next cycle with idle = 1 and outWptr = 16'h8000, the null value for the default width. Any other accepted command clears idle.
- R8: memReq, memWe, memAddr and memWdata stay stable until memAck. busy is high from the cycle after acceptance until the command completes, and memReq is never high while busy is low. doneValid is a one-cycle pulse in the cycle after completion.
- R9: A command presented while busy is high is ignored and changes neither the queues nor the memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present; taken only when busy is low |
| cmdOp | input | 1 | 0 enqueue, 1 dequeue |
| cmdWptr | input | W | Workspace pointer of the process to enqueue |
| cmdIptr | input | W | Resume address of the process to enqueue |
| busy | output | 1 | A command is in progress |
| doneValid | output | 1 | One-cycle pulse when a command has finished |
| idle | output | 1 | Last dequeue found both queues empty |
| outWptr | output | W | Workspace pointer of the dequeued process |
| outIptr | output | W | Resume address of the dequeued process |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | W | Byte address of the access |
| memWdata | output | W | Write data |
| memAck | input | 1 | Access accepted; read data valid this cycle |
| memRdata | input | W | Read data |

## Verification
A new command can arrive in the same cycle that the previous command's final memory acknowledge completes it. Busy is still high in that cycle, so the new command must be dropped. The bench provokes this by holding a dequeue on the command inputs for one cycle right after an enqueue is accepted, while the memory model acknowledges with zero to two cycles of delay. This often lines the intruding command up with the completing acknowledge. The bench judges the result in two ways. The memory log for that command must contain only the enqueue's own writes. Every later dequeue must still match the bench's own queue model, which never saw the intruder.

// File: rtl/rqPkg.sv
package rqPkg;

  typedef enum logic [1:0] {
    ADDR_SELF_IP,
    ADDR_BACK_LINK,
    ADDR_FRONT_IP,
    ADDR_FRONT_LINK
  } addrSel_e;

  typedef enum logic [2:0] {
    S_FREE,
    S_ENQ_IP,
    S_ENQ_LINK,
    S_DEQ_IP,
    S_DEQ_LINK
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchCmd;
    addrSel_e addrSel;
    logic     memWe;
    logic     setBoth;
    logic     setBack;
    logic     setFront;
    logic     setEmpty;
    logic     capOut;
    logic     markIdle;
    logic     finish;
  } rqStrobe_t;

  localparam int unsigned IP_OFFSET   = 4;
  localparam int unsigned LINK_OFFSET = 8;

endpackage

// File: rtl/rqDatapath.sv
module rqDatapath
  import rqPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  rqStrobe_t    stb,
  input  logic         cmdOp,
  input  logic [W-1:0] cmdWptr,
  input  logic [W-1:0] cmdIptr,
  input  logic [W-1:0] memRdata,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  output logic [W-1:0] outWptr,
  output logic [W-1:0] outIptr,
  output logic         idle,
  output logic         bothEmpty,
  output logic         curEmpty,
  output logic         curSingle
);

  localparam int NQ = 2;
  localparam logic [W-1:0] NullPtr = {1'b1, {(W-1){1'b0}}};

  logic [NQ-1:0][W-1:0] frontAll;
  logic [NQ-1:0][W-1:0] backAll;
  logic [NQ-1:0]        emptyAll;
  logic [W-1:0]         curWptr;
  logic [W-1:0]         curIptr;
  logic                 curQ;

  function automatic logic [W-1:0] slotAddr(input logic [W-1:0] p, input int unsigned off);
    return {p[W-1:1], 1'b0} - W'(off);
  endfunction

  // command latch and queue choice
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWptr <= '0;
      curIptr <= '0;
      curQ    <= 1'b0;
    end else if (stb.latchCmd) begin
      curWptr <= cmdWptr;
      curIptr <= cmdIptr;
      curQ    <= cmdOp ? emptyAll[0] : cmdWptr[0];
    end
  end

  // one front/back pair per priority
  for (genvar g = 0; g < NQ; g++) begin : gQueue
    logic [W-1:0] frontR;
    logic [W-1:0] backR;
    logic         hit;
    assign hit = (curQ == 1'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        frontR <= NullPtr;
        backR  <= NullPtr;
      end else if (hit) begin
        if (stb.setBoth) begin
          frontR <= curWptr;
          backR  <= curWptr;
        end else if (stb.setBack) begin
          backR  <= curWptr;
        end else if (stb.setFront) begin
          frontR <= memRdata;
        end else if (stb.setEmpty) begin
          frontR <= NullPtr;
          backR  <= NullPtr;
        end
      end
    end
    assign frontAll[g] = frontR;
    assign backAll[g]  = backR;
    assign emptyAll[g] = (frontR == NullPtr);
  end

  assign bothEmpty = &emptyAll;
  assign curEmpty  = emptyAll[curQ];
  assign curSingle = (frontAll[curQ] == backAll[curQ]);

  // address and write-data selection
  always_comb begin
    memWdata = curWptr;
    unique case (stb.addrSel)
      ADDR_SELF_IP: begin
        memAddr  = slotAddr(curWptr, IP_OFFSET);
        memWdata = curIptr;
      end
      ADDR_BACK_LINK:  memAddr = slotAddr(backAll[curQ], LINK_OFFSET);
      ADDR_FRONT_IP:   memAddr = slotAddr(frontAll[curQ], IP_OFFSET);
      ADDR_FRONT_LINK: memAddr = slotAddr(frontAll[curQ], LINK_OFFSET);
      default:         memAddr = '0;
    endcase
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outWptr <= NullPtr;
      outIptr <= '0;
      idle    <= 1'b0;
    end else begin
      if (stb.markIdle) begin
        idle    <= 1'b1;
        outWptr <= NullPtr;
      end else if (stb.latchCmd) begin
        idle    <= 1'b0;
      end
      if (stb.capOut) begin
        outWptr <= frontAll[curQ];
        outIptr <= memRdata;
      end
    end
  end

endmodule

// File: rtl/rqControl.sv
module rqControl
  import rqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      cmdOp,
  input  logic      memAck,
  input  logic      bothEmpty,
  input  logic      curEmpty,
  input  logic      curSingle,
  output rqStrobe_t stb,
  output logic      memReq,
  output logic      busy,
  output logic      doneValid
);

  ctrlState_e state, stateNext;

  always_comb begin
    stb       = '0;
    stb.addrSel = ADDR_SELF_IP;
    memReq    = 1'b0;
    stateNext = state;
    unique case (state)
      S_FREE: begin
        if (cmdValid) begin
          if (!cmdOp) begin
            stb.latchCmd = 1'b1;
            stateNext    = S_ENQ_IP;
          end else if (bothEmpty) begin
            stb.markIdle = 1'b1;
            stb.finish   = 1'b1;
          end else begin
            stb.latchCmd = 1'b1;
            stateNext    = S_DEQ_IP;
          end
        end
      end
      S_ENQ_IP: begin
        memReq      = 1'b1;
        stb.memWe   = 1'b1;
        stb.addrSel = ADDR_SELF_IP;
        if (memAck) begin
          if (curEmpty) begin
            stb.setBoth = 1'b1;
            stb.finish  = 1'b1;
            stateNext   = S_FREE;
          end else begin
            stateNext   = S_ENQ_LINK;
          end
        end
      end
      S_ENQ_LINK: begin
        memReq      = 1'b1;
        stb.memWe   = 1'b1;
        stb.addrSel = ADDR_BACK_LINK;
        if (memAck) begin
          stb.setBack = 1'b1;
          stb.finish  = 1'b1;
          stateNext   = S_FREE;
        end
      end
      S_DEQ_IP: begin
        memReq      = 1'b1;
        stb.addrSel = ADDR_FRONT_IP;
        if (memAck) begin
          stb.capOut = 1'b1;
          if (curSingle) begin
            stb.setEmpty = 1'b1;
            stb.finish   = 1'b1;
            stateNext    = S_FREE;
          end else begin
            stateNext    = S_DEQ_LINK;
          end
        end
      end
      S_DEQ_LINK: begin
        memReq      = 1'b1;
        stb.addrSel = ADDR_FRONT_LINK;
        if (memAck) begin
          stb.setFront = 1'b1;
          stb.finish   = 1'b1;
          stateNext    = S_FREE;
        end
      end
      default: stateNext = S_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_FREE;
      doneValid <= 1'b0;
    end else begin
      state     <= stateNext;
      doneValid <= stb.finish;
    end
  end

  assign busy = (state != S_FREE);

endmodule

// File: rtl/procQueueMgr.sv
module procQueueMgr
  import rqPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         cmdOp,
  input  logic [W-1:0] cmdWptr,
  input  logic [W-1:0] cmdIptr,
  output logic         busy,
  output logic         doneValid,
  output logic         idle,
  output logic [W-1:0] outWptr,
  output logic [W-1:0] outIptr,
  output logic         memReq,
  output logic         memWe,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  input  logic         memAck,
  input  logic [W-1:0] memRdata
);

  rqStrobe_t stb;
  logic      bothEmpty;
  logic      curEmpty;
  logic      curSingle;

  rqControl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .memAck    (memAck),
    .bothEmpty (bothEmpty),
    .curEmpty  (curEmpty),
    .curSingle (curSingle),
    .stb       (stb),
    .memReq    (memReq),
    .busy      (busy),
    .doneValid (doneValid)
  );

  rqDatapath #(.W(W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cmdOp     (cmdOp),
    .cmdWptr   (cmdWptr),
    .cmdIptr   (cmdIptr),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .outWptr   (outWptr),
    .outIptr   (outIptr),
    .idle      (idle),
    .bothEmpty (bothEmpty),
    .curEmpty  (curEmpty),
    .curSingle (curSingle)
  );

  assign memWe = stb.memWe;

endmodule

// File: rtl/rqChecker.sv
module rqChecker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         cmdValid,
  input logic         busy,
  input logic         doneValid,
  input logic         idle,
  input logic [W-1:0] outWptr,
  input logic         memReq,
  input logic         memWe,
  input logic [W-1:0] memAddr,
  input logic [W-1:0] memWdata,
  input logic         memAck
);

  localparam logic [W-1:0] NullPtr = {1'b1, {(W-1){1'b0}}};

  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  p_quiet_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  p_done_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && !cmdValid |=> !doneValid);

  p_idle_null_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && idle |-> outWptr == NullPtr);

  p_word_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);

endmodule

bind procQueueMgr rqChecker #(.W(W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .busy      (busy),
  .doneValid (doneValid),
  .idle      (idle),
  .outWptr   (outWptr),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .memAck    (memAck)
);

// File: tb/tb_procQueueMgr.sv
module tb_procQueueMgr;

  localparam int W = 16;
  localparam logic [W-1:0] NULLP = 16'h8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdOp = 1'b0;
  logic [W-1:0] cmdWptr = '0, cmdIptr = '0;
  logic busy, doneValid, idle, memReq, memWe, memAck;
  logic [W-1:0] outWptr, outIptr, memAddr, memWdata, memRdata;

  always #5 clk = ~clk;

  procQueueMgr #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdWptr(cmdWptr), .cmdIptr(cmdIptr), .busy(busy), .doneValid(doneValid),
    .idle(idle), .outWptr(outWptr), .outIptr(outIptr), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata)
  );

  int checks = 0, errors = 0;
  logic [W-1:0] mem [logic [W-1:0]];
  logic         logWe [$];
  logic [W-1:0] logAddr [$];
  logic [W-1:0] logData [$];
  logic [W-1:0] hiQ [$];
  logic [W-1:0] loQ [$];
  logic [W-1:0] ipOf [logic [W-1:0]];
  bit           queued [int];
  int           waitCnt = 0;

  // memory model with 0..2 cycle acknowledge delay
  initial begin
    memAck = 1'b0;
    memRdata = '0;
    forever begin
      @(negedge clk);
      if (memAck || !rstN) begin
        memAck = 1'b0;
      end else if (memReq) begin
        if (waitCnt == 0) begin
          memAck = 1'b1;
          if (memWe) mem[memAddr] = memWdata;
          else memRdata = mem.exists(memAddr) ? mem[memAddr] : '0;
          logWe.push_back(memWe);
          logAddr.push_back(memAddr);
          logData.push_back(memWe ? memWdata : memRdata);
          waitCnt = int'($urandom % 3);
        end else begin
          waitCnt--;
        end
      end
    end
  end

  function automatic logic [W-1:0] slot(input logic [W-1:0] p, input int off);
    return {p[W-1:1], 1'b0} - W'(off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runCmd(input logic op, input logic [W-1:0] w, input logic [W-1:0] ip,
                        input bit intrude);
    int cyc = 0;
    logWe.delete(); logAddr.delete(); logData.delete();
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdWptr = w; cmdIptr = ip;
    @(negedge clk);
    cmdValid = 1'b0;
    if (intrude && busy) begin
      // R9: dequeue offered while busy must be dropped
      cmdValid = 1'b1; cmdOp = 1'b1; cmdWptr = 16'h0FF0;
      @(negedge clk);
      cmdValid = 1'b0;
    end
    while (!doneValid && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 1000) chk("watchdog", 32'd1, 32'd0);
  endtask

  task automatic doEnq(input logic [W-1:0] w, input logic [W-1:0] ip, input bit intrude);
    logic [W-1:0] oldBack;
    bit wasEmpty;
    if (w[0]) begin wasEmpty = (loQ.size() == 0); if (!wasEmpty) oldBack = loQ[$]; end
    else      begin wasEmpty = (hiQ.size() == 0); if (!wasEmpty) oldBack = hiQ[$]; end
    runCmd(1'b0, w, ip, intrude);
    chk("R3 access count", logWe.size(), wasEmpty ? 1 : 2);
    if (logWe.size() >= 1) begin
      chk("R2 ip write we",   logWe[0],   1);
      chk("R2 ip write addr", logAddr[0], slot(w, 4));
      chk("R2 ip write data", logData[0], ip);
    end
    if (!wasEmpty && logWe.size() == 2) begin
      chk("R3 link write addr", logAddr[1], slot(oldBack, 8));
      chk("R3 link write data", logData[1], w);
    end
    chk("R7 idle cleared", idle, 0);
    if (w[0]) loQ.push_back(w); else hiQ.push_back(w);
    ipOf[w] = ip;
  endtask

  task automatic doDeq();
    logic [W-1:0] f;
    bit last, fromHi;
    fromHi = (hiQ.size() != 0);
    if (!fromHi && loQ.size() == 0) begin
      runCmd(1'b1, 16'h0, 16'h0, 1'b0);
      chk("R7 idle flag", idle, 1);
      chk("R7 null wptr", outWptr, NULLP);
      chk("R7 no access", logWe.size(), 0);
      return;
    end
    f = fromHi ? hiQ.pop_front() : loQ.pop_front();
    last = fromHi ? (hiQ.size() == 0) : (loQ.size() == 0);
    runCmd(1'b1, 16'h0, 16'h0, 1'b0);
    chk("R4/R5 wptr order", outWptr, f);
    chk("R5 iptr", outIptr, ipOf[f]);
    chk("R6 read count", logWe.size(), last ? 1 : 2);
    if (logWe.size() >= 1) chk("R5 ip read addr", logAddr[0], slot(f, 4));
    if (!last && logWe.size() == 2) chk("R5 link read addr", logAddr[1], slot(f, 8));
    chk("R7 idle low", idle, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", doneValid, 0);
    chk("R1 idle", idle, 0);
    chk("R1 memReq", memReq, 0);
    doDeq();                                   // R1/R7: empty after reset
    // R8: done is a single-cycle pulse
    @(negedge clk);
    chk("R8 done pulse", doneValid, 0);
    // R4 priority: low enqueued first, high served first
    doEnq(16'h0101, 16'h1111, 1'b0);
    doEnq(16'h0200, 16'h2222, 1'b0);
    doDeq(); doDeq(); doDeq();
    // R5 FIFO within high queue, R3 link writes, R6 last entry
    doEnq(16'h0300, 16'h3333, 1'b0);
    doEnq(16'h0310, 16'h3434, 1'b0);
    doEnq(16'h0320, 16'h3535, 1'b0);
    doDeq(); doDeq(); doDeq(); doDeq();
    // R8: busy visible after acceptance
    logWe.delete();
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 1'b0; cmdWptr = 16'h0401; cmdIptr = 16'h4444;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R8 busy after accept", busy, 1);
    while (!doneValid) @(negedge clk);
    loQ.push_back(16'h0401); ipOf[16'h0401] = 16'h4444;
    // R9: intruding commands while busy
    doEnq(16'h0411, 16'h4545, 1'b1);
    doEnq(16'h0420, 16'h4646, 1'b1);
    doDeq(); doDeq(); doDeq(); doDeq();
    // random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      k = 2 + int'($urandom % 60);
      if (!queued.exists(k) && ($urandom % 3 != 0)) begin
        queued[k] = 1'b1;
        doEnq(W'(k * 64) | W'($urandom % 2), W'($urandom), ($urandom % 4) == 0);
      end else begin
        int h;
        logic [W-1:0] nxt;
        h = -1;
        if (hiQ.size() != 0) nxt = hiQ[0];
        else if (loQ.size() != 0) nxt = loQ[0];
        else nxt = NULLP;
        if (nxt != NULLP) h = int'(nxt) / 64;
        doDeq();
        if (h >= 0) queued.delete(h);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule